// File: doc/BRIEF.md
# Interval Timer Register Interface

This block is the bus side of a three-channel interval timer. A host reaches it through a 2-bit address, an 8-bit write port, an 8-bit read port and single-cycle read and write strobes. Address 3 takes control words. Addresses 0 to 2 are the data ports of channels 0 to 2. For each channel the block holds the access mode, the counting mode and the decimal flag. It also keeps separate byte sequencing for reads and for writes, a held copy of the count and a held status byte.

Each channel has a plain reloading down counter, so the interface can be exercised on its own. A completed reload value goes to the counter one clock later. The counter steps down on each pulse of its counting enable and starts over from the reload value when it reaches 1. Each channel's output level comes from outside the block and is only sampled into the status byte. Output waveforms, gating and decimal counting are not part of this block.

Top module: `pit_regif`

## Requirements
- R1: After reset every channel is in word access mode (access field 3), counting mode 0, binary, with count 0 and nothing held. A status snapshot then reads {level, 0, 2'b11, 3'b000, 0}, and live reads of the count return 0x00.
- R2: A read of address 3 returns 0xFF and changes no sequencing or held state.
- R3: A control word {ch[7:6] not 3, acc[5:4] not 0, mode[3:1], dec[0]} stores acc, mode and dec for that channel. It also restarts both the read and the write byte sequence of that channel at the low byte.
- R4: Data writes build the reload value from the access mode. Access 1 loads {0x00, byte}. Access 2 loads {byte, 0x00}. Access 3 holds the first byte and loads {second, first} on the second byte.
- R5: The counter takes a new reload value on the clock after the loading write. It decrements once per enable pulse and reloads when an enable arrives at count 1. A reload value of 0 stands for 65536, whose low 16 bits read as 0x0000.
- R6: Live count reads give the low byte in access 1 and the high byte in access 2. In access 3 they alternate low then high, and this toggle is independent of the write toggle.
- R7: A latch request (acc[5:4]=0, or a snapshot with bit 5 low) copies the live count. It is ignored while that channel still holds an unread latched count.
- R8: A held count is read out in the access mode that was in force when it was taken. Access 1 gives the low byte once, access 2 gives the high byte once, and access 3 gives low then high. The hold is then released.
- R9: A snapshot word (bits 7:6 = 3) acts on every channel n whose bit n+1 is set. With bit 5 low it latches the count, and with bit 4 low it takes a status byte. A status byte is not replaced while one is still unread.
- R10: The status byte is {level[7], 0[6], acc[5:4], mode[3:1], dec[0]}, with the level sampled when the snapshot word is written.
- R11: A data read returns an unread status byte first and clears it. If there is none, it returns a held count. Only when neither is present does it return the live count.
- R12: When the read and write strobes are both high in one cycle, only the write acts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0 to 2 data ports, 3 control |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Read data, valid during the read strobe cycle |
| tick | input | 3 | Per-channel counting enable |
| out_lvl | input | 3 | Per-channel output level, sampled into status |
| count | output | 48 | Live 16-bit counts, channel n in bits 16n+15:16n |

## Verification
The assertions assume that the strobes are synchronous. A read that consumes a byte is one strobe cycle, with the address held through it, and a counting pulse in the cycle that takes a reload is overridden by the reload. The bench drives every input at the falling edge and gives each access one strobe cycle followed by an idle cycle, so each reload completes before the next access. In the random phase the counting enables stay low, so the live count it reads back is a value the bench can predict.

// File: rtl/pit_regif.sv
module pit_regif (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        wr_en,
  input  logic        rd_en,
  output logic [7:0]  rdata,
  input  logic [2:0]  tick,
  input  logic [2:0]  out_lvl,
  output logic [47:0] count
);
  logic [2:0][1:0]  acc, lat_st;
  logic [2:0][2:0]  mode;
  logic [2:0]       dec, rd_tog, wr_tog, st_pend, ld_pend;
  logic [2:0][7:0]  wlat, st_byte;
  logic [2:0][15:0] lat_cnt, rld;
  logic [2:0][16:0] cnt;

  wire       is_ctl = (addr == 2'd3);
  wire [1:0] ch     = is_ctl ? 2'd0 : addr;
  wire [1:0] sel    = wdata[7:6];
  wire [1:0] wacc   = wdata[5:4];
  wire       do_rd  = rd_en && !wr_en && !is_ctl;

  assign count = {cnt[2][15:0], cnt[1][15:0], cnt[0][15:0]};

  always_comb begin
    if (is_ctl)                   rdata = 8'hFF;
    else if (st_pend[ch])         rdata = st_byte[ch];
    else if (lat_st[ch] == 2'd2)  rdata = lat_cnt[ch][15:8];
    else if (lat_st[ch] != 2'd0)  rdata = lat_cnt[ch][7:0];
    else if (acc[ch] == 2'd2 || (acc[ch] == 2'd3 && rd_tog[ch]))
                                  rdata = cnt[ch][15:8];
    else                          rdata = cnt[ch][7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= {3{2'd3}};
      lat_st  <= '0;
      mode    <= '0;
      dec     <= '0;
      rd_tog  <= '0;
      wr_tog  <= '0;
      st_pend <= '0;
      ld_pend <= '0;
      wlat    <= '0;
      st_byte <= '0;
      lat_cnt <= '0;
      rld     <= '0;
      cnt     <= '0;
    end else begin
      for (int n = 0; n < 3; n++) begin
        if (ld_pend[n])
          cnt[n] <= (rld[n] == 16'd0) ? 17'h10000 : {1'b0, rld[n]};
        else if (tick[n])
          cnt[n] <= (cnt[n] <= 17'd1) ? ((rld[n] == 16'd0) ? 17'h10000 : {1'b0, rld[n]})
                                      : cnt[n] - 17'd1;
        ld_pend[n] <= 1'b0;

        if (wr_en && is_ctl) begin
          if (sel == 2'd3) begin
            if (wdata[n+1]) begin
              if (!wdata[5] && lat_st[n] == 2'd0) begin
                lat_cnt[n] <= cnt[n][15:0];
                lat_st[n]  <= acc[n];
              end
              if (!wdata[4] && !st_pend[n]) begin
                st_byte[n] <= {out_lvl[n], 1'b0, acc[n], mode[n], dec[n]};
                st_pend[n] <= 1'b1;
              end
            end
          end else if (sel == 2'(n)) begin
            if (wacc == 2'd0) begin
              if (lat_st[n] == 2'd0) begin
                lat_cnt[n] <= cnt[n][15:0];
                lat_st[n]  <= acc[n];
              end
            end else begin
              acc[n]    <= wacc;
              mode[n]   <= wdata[3:1];
              dec[n]    <= wdata[0];
              rd_tog[n] <= 1'b0;
              wr_tog[n] <= 1'b0;
            end
          end
        end else if (wr_en && addr == 2'(n)) begin
          case (acc[n])
            2'd1: begin
              rld[n]     <= {8'h00, wdata};
              ld_pend[n] <= 1'b1;
            end
            2'd2: begin
              rld[n]     <= {wdata, 8'h00};
              ld_pend[n] <= 1'b1;
            end
            default: begin
              if (!wr_tog[n]) begin
                wlat[n]   <= wdata;
                wr_tog[n] <= 1'b1;
              end else begin
                rld[n]     <= {wdata, wlat[n]};
                ld_pend[n] <= 1'b1;
                wr_tog[n]  <= 1'b0;
              end
            end
          endcase
        end else if (do_rd && addr == 2'(n)) begin
          if (st_pend[n])              st_pend[n] <= 1'b0;
          else if (lat_st[n] == 2'd3)  lat_st[n]  <= 2'd2;
          else if (lat_st[n] != 2'd0)  lat_st[n]  <= 2'd0;
          else if (acc[n] == 2'd3)     rd_tog[n]  <= !rd_tog[n];
        end
      end
    end
  end
endmodule

// File: rtl/pit_regif_chk.sv
module pit_regif_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic        tick0,
  input logic        ld_pend0,
  input logic [15:0] rld0,
  input logic [16:0] cnt0,
  input logic [1:0]  lat_st0,
  input logic [15:0] lat_cnt0,
  input logic        st_pend0,
  input logic [7:0]  st_byte0
);
  wire rd0 = rd_en && !wr_en && addr == 2'd0;

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pend0 |=> (cnt0[15:0] == $past(rld0)) && (cnt0 != 17'd0));

  p_decr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_pend0 && tick0 && cnt0 > 17'd1) |=> cnt0 == $past(cnt0) - 17'd1);

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_pend0 && tick0 && cnt0 == 17'd1) |=> cnt0[15:0] == $past(rld0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_pend0 && !tick0) |=> $stable(cnt0));

  p_latch_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_st0 != 2'd0) |=> $stable(lat_cnt0));

  p_stat_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_pend0 |=> $stable(st_byte0));

  p_stat_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && st_pend0) |=> (!st_pend0 && $stable(lat_st0)));

  p_lat_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && !st_pend0 && lat_st0 == 2'd3) |=> lat_st0 == 2'd2);

  p_ctl_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 2'd3) |=> ($stable(lat_st0) && $stable(st_pend0)));
endmodule

bind pit_regif pit_regif_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .tick0    (tick[0]),
  .ld_pend0 (ld_pend[0]),
  .rld0     (rld[0]),
  .cnt0     (cnt[0]),
  .lat_st0  (lat_st[0]),
  .lat_cnt0 (lat_cnt[0]),
  .st_pend0 (st_pend[0]),
  .st_byte0 (st_byte[0])
);

// File: tb/tb_pit_regif.sv
`timescale 1ns/1ps
module tb_pit_regif;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  rdata;
  logic [2:0]  tick = '0, out_lvl = '0;
  logic [47:0] count;

  always #4 clk = ~clk;

  pit_regif dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
                 .rd_en(rd_en), .rdata(rdata), .tick(tick), .out_lvl(out_lvl), .count(count));

  int n_chk = 0, n_err = 0;
  logic [1:0]  m_acc[3], m_ls[3];
  logic [2:0]  m_mode[3];
  logic        m_dec[3], m_rt[3], m_wt[3], m_sp[3];
  logic [7:0]  m_wl[3], m_sb[3];
  logic [15:0] m_lc[3], m_rld[3];
  logic [16:0] m_cnt[3];

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] eff(logic [15:0] v);
    return (v == 16'd0) ? 17'h10000 : {1'b0, v};
  endfunction

  task automatic m_reset();
    for (int n = 0; n < 3; n++) begin
      m_acc[n] = 2'd3; m_ls[n] = 2'd0; m_mode[n] = 3'd0; m_dec[n] = 1'b0;
      m_rt[n] = 1'b0; m_wt[n] = 1'b0; m_sp[n] = 1'b0; m_wl[n] = 8'h00;
      m_sb[n] = 8'h00; m_lc[n] = 16'h0; m_rld[n] = 16'h0; m_cnt[n] = 17'h0;
    end
  endtask

  task automatic m_latch(int n);
    if (m_ls[n] == 2'd0) begin
      m_lc[n] = m_cnt[n][15:0];
      m_ls[n] = m_acc[n];
    end
  endtask

  task automatic m_load(int n, logic [15:0] v);
    m_rld[n] = v;
    m_cnt[n] = eff(v);
  endtask

  task automatic m_write(logic [1:0] a, logic [7:0] d);
    if (a == 2'd3) begin
      if (d[7:6] == 2'd3) begin
        for (int n = 0; n < 3; n++) begin
          if (d[n+1]) begin
            if (!d[5]) m_latch(n);
            if (!d[4] && !m_sp[n]) begin
              m_sb[n] = {out_lvl[n], 1'b0, m_acc[n], m_mode[n], m_dec[n]};
              m_sp[n] = 1'b1;
            end
          end
        end
      end else begin
        int n = int'(d[7:6]);
        if (d[5:4] == 2'd0) m_latch(n);
        else begin
          m_acc[n] = d[5:4]; m_mode[n] = d[3:1]; m_dec[n] = d[0];
          m_rt[n] = 1'b0; m_wt[n] = 1'b0;
        end
      end
    end else begin
      int n = int'(a);
      if (m_acc[n] == 2'd1) m_load(n, {8'h00, d});
      else if (m_acc[n] == 2'd2) m_load(n, {d, 8'h00});
      else if (!m_wt[n]) begin m_wl[n] = d; m_wt[n] = 1'b1; end
      else begin m_load(n, {d, m_wl[n]}); m_wt[n] = 1'b0; end
    end
  endtask

  task automatic m_read(logic [1:0] a, output logic [7:0] e);
    if (a == 2'd3) e = 8'hFF;
    else begin
      int n = int'(a);
      if (m_sp[n]) begin e = m_sb[n]; m_sp[n] = 1'b0; end
      else if (m_ls[n] == 2'd3) begin e = m_lc[n][7:0]; m_ls[n] = 2'd2; end
      else if (m_ls[n] == 2'd2) begin e = m_lc[n][15:8]; m_ls[n] = 2'd0; end
      else if (m_ls[n] == 2'd1) begin e = m_lc[n][7:0]; m_ls[n] = 2'd0; end
      else if (m_acc[n] == 2'd1) e = m_cnt[n][7:0];
      else if (m_acc[n] == 2'd2) e = m_cnt[n][15:8];
      else begin
        e = m_rt[n] ? m_cnt[n][15:8] : m_cnt[n][7:0];
        m_rt[n] = !m_rt[n];
      end
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    m_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_rd(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b1;
    m_write(a, d);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, string tag, output logic [7:0] got);
    logic [7:0] e;
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    got = rdata;
    m_read(a, e);
    chk(tag, got, e);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_lit(logic [1:0] a, logic [7:0] lit, string tag);
    logic [7:0] g;
    rd(a, tag, g);
    chk(tag, g, lit);
  endtask

  task automatic ticks(int n, int k);
    @(negedge clk);
    tick[n] = 1'b1;
    repeat (k) begin
      @(negedge clk);
      m_cnt[n] = (m_cnt[n] <= 17'd1) ? eff(m_rld[n]) : m_cnt[n] - 17'd1;
    end
    tick[n] = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] g;
    void'($urandom(32'd2024));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    wr(2'd3, 8'hE2);
    rd_lit(2'd0, 8'h30, "R1 reset status");
    rd_lit(2'd1, 8'h00, "R1 reset count low");
    rd_lit(2'd1, 8'h00, "R1 reset count high");

    wr(2'd3, 8'h34);
    wr(2'd0, 8'h05);
    wr(2'd0, 8'h00);
    rd_lit(2'd0, 8'h05, "R6 word low");
    rd_lit(2'd0, 8'h00, "R6 word high");
    ticks(0, 4);
    rd_lit(2'd0, 8'h01, "R5 decrement");
    rd_lit(2'd0, 8'h00, "R5 decrement high");
    ticks(0, 1);
    rd_lit(2'd0, 8'h05, "R5 reload at one");
    rd(2'd0, "R6 toggle", g);

    wr(2'd3, 8'h50);
    wr(2'd1, 8'h00);
    rd_lit(2'd1, 8'h00, "R5 zero is 65536");
    ticks(1, 1);
    rd_lit(2'd1, 8'hFF, "R5 after 65536");
    wr(2'd3, 8'h60);
    rd_lit(2'd1, 8'hFF, "R6 high only");
    wr(2'd1, 8'h12);
    rd_lit(2'd1, 8'h12, "R4 high only load");

    wr(2'd3, 8'hB4);
    wr(2'd2, 8'h34);
    wr(2'd2, 8'h12);
    wr(2'd3, 8'h80);
    ticks(2, 3);
    wr(2'd3, 8'h80);
    rd_lit(2'd2, 8'h34, "R7 first latch kept");
    rd_lit(2'd2, 8'h12, "R8 latch word high");
    rd_lit(2'd2, 8'h31, "R8 released to live");
    rd_lit(2'd2, 8'h12, "R6 live high");

    out_lvl = 3'b100;
    wr(2'd3, 8'hCE);
    out_lvl = 3'b000;
    rd_lit(2'd2, 8'hB4, "R10 status format");
    rd_lit(2'd2, 8'h31, "R11 latch after status");
    rd_lit(2'd2, 8'h12, "R8 latch high");
    wr(2'd3, 8'hE2);
    rd_lit(2'd0, 8'h34, "R9 status not replaced");
    rd_lit(2'd0, 8'h05, "R9 multi latch ch0 low");
    rd_lit(2'd0, 8'h00, "R9 multi latch ch0 high");
    rd_lit(2'd1, 8'h20, "R9 multi status ch1");
    rd_lit(2'd1, 8'h12, "R8 high only latch");
    rd_lit(2'd1, 8'h12, "R11 live after latch");

    wr(2'd3, 8'h00);
    wr_rd(2'd0, 8'h77);
    rd_lit(2'd0, 8'h05, "R12 latch not consumed");
    rd_lit(2'd0, 8'h00, "R12 latch high");
    wr(2'd0, 8'h00);
    rd_lit(2'd0, 8'h77, "R12 write took effect");

    wr(2'd3, 8'h34);
    wr(2'd0, 8'h99);
    rd(2'd0, "R3 pre toggle", g);
    wr(2'd3, 8'h34);
    wr(2'd0, 8'h22);
    wr(2'd0, 8'h01);
    rd_lit(2'd0, 8'h22, "R3 sequences restarted");
    rd_lit(2'd0, 8'h01, "R4 word load");
    rd_lit(2'd3, 8'hFF, "R2 control read");
    rd_lit(2'd0, 8'h22, "R2 no side effect");

    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 10);
      logic [1:0] a = 2'($urandom % 3);
      out_lvl = 3'($urandom);
      case (r)
        0: wr(2'd3, {a, 2'($urandom), 3'($urandom), 1'b0});
        1: wr(2'd3, {2'b11, 6'($urandom)});
        2, 3: wr(a, 8'($urandom));
        4: rd(2'd3, "R2 random", g);
        default: rd(a, "R11 random", g);
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule